// File: doc/BRIEF.md
# Unified AES-128 Encrypt/Decrypt Round Datapath

This block computes one AES-128 round per clock cycle on a single 128-bit state register. Encryption and decryption share that register and one bank of sixteen GF(2^8) inverters. The register boundary is moved so that every round begins with field inversion. After the inversion, each direction applies one merged linear layer. On the encrypt side this layer is the forward affine map fused with MixColumns. On the decrypt side it is InvMixColumns fused with the inverse affine map. The next state is chosen by a single 4:1 selector.

An external key scheduler supplies one 128-bit round key per cycle. It follows the timing in R3 and counts cycles from the accepted start. There is no overlap between blocks, so each result is available before the next block starts. This keeps the block usable for chaining modes such as CBC. While a block is being processed, the data-direction path that the latched mode does not use is held at zero. During that time the result port shows the intermediate state. The final value holds until the next block starts.

Top module: `aesrd_core`

## Requirements
- R1: With mode=0 at an accepted start, the result after completion is the AES-128 encryption of text. Byte 0 of every 128-bit value sits in bits 127:120, and bytes fill the 4x4 state column by column (byte i is row i%4, column i/4).
- R2: With mode=1 at an accepted start, the result after completion is the AES-128 decryption of text. Encrypting and then decrypting with the same key returns the original text.
- R3: rkey is sampled at the start edge and at each of the NR edges that follow. At edge k (k=0 at start), encryption uses expanded key k and decryption uses expanded key NR-k.
- R4: done goes high in the cycle after the NR-th edge following an accepted start. It stays high for exactly that one cycle.
- R5: start is ignored while a block is being processed. It neither alters the result nor shifts the timing.
- R6: While idle with start low, result keeps its value, whatever text, mode and rkey do.
- R7: During synchronous active-low reset, done and result are cleared to zero.
- R8: mode is latched at the accepted start. Changes to mode during processing have no effect.
- R9: A start given in the same cycle that done is high is accepted, and it produces a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block when idle |
| mode | input | 1 | 0 = encrypt, 1 = decrypt |
| text | input | 128 | Plaintext or ciphertext input |
| rkey | input | 128 | Round key for the current edge |
| result | output | 128 | State register / final result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main function is tried with two standard known-answer vectors, run in both directions. These catch a wrong affine constant, a wrong row rotation, a wrong byte order or a wrong key order, all of which a round trip alone would miss. A sweep of 256 encrypt-then-decrypt round trips follows. Each one places a walking byte value in a rotating position under a varying key, which exposes any byte lane or inverter input that is mishandled. Blocks run with start and mode toggling throughout processing show whether those inputs leak in. An idle hold with moving inputs shows whether the result can be disturbed. Back-to-back blocks started on the done cycle test the hand-off between blocks.

// File: rtl/aesrd_pkg.sv
// Shared helpers for the AES round datapath: GF(2^8) arithmetic and
// whole-state byte permutations / linear maps. Byte 0 is bits 127:120,
// bytes are column-major in the 4x4 state.
package aesrd_pkg;

    localparam int BLK_W = 128;
    localparam logic [BLK_W-1:0] AFF_K  = {16{8'h63}};
    localparam logic [BLK_W-1:0] IAFF_K = {16{8'h05}};

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xt(sh);
        end
        return acc;
    endfunction

    function automatic logic [127:0] shift_rows(input logic [127:0] s);
        logic [127:0] o;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+r)%4)) -: 8];
        return o;
    endfunction

    function automatic logic [127:0] inv_shift_rows(input logic [127:0] s);
        logic [127:0] o;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+4-r)%4)) -: 8];
        return o;
    endfunction

    function automatic logic [127:0] mix_all(input logic [127:0] s);
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = s[127-32*c -: 8];  a1 = s[119-32*c -: 8];
            a2 = s[111-32*c -: 8];  a3 = s[103-32*c -: 8];
            o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
            o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
            o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
            o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
        return o;
    endfunction

    function automatic logic [127:0] inv_mix_all(input logic [127:0] s);
        logic [127:0] o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < 4; c++) begin
            a0 = s[127-32*c -: 8];  a1 = s[119-32*c -: 8];
            a2 = s[111-32*c -: 8];  a3 = s[103-32*c -: 8];
            o[127-32*c -: 8] = gf_mul(a0,8'h0e) ^ gf_mul(a1,8'h0b) ^ gf_mul(a2,8'h0d) ^ gf_mul(a3,8'h09);
            o[119-32*c -: 8] = gf_mul(a0,8'h09) ^ gf_mul(a1,8'h0e) ^ gf_mul(a2,8'h0b) ^ gf_mul(a3,8'h0d);
            o[111-32*c -: 8] = gf_mul(a0,8'h0d) ^ gf_mul(a1,8'h09) ^ gf_mul(a2,8'h0e) ^ gf_mul(a3,8'h0b);
            o[103-32*c -: 8] = gf_mul(a0,8'h0b) ^ gf_mul(a1,8'h0d) ^ gf_mul(a2,8'h09) ^ gf_mul(a3,8'h0e);
        end
        return o;
    endfunction

    // Linear part of the forward affine map, applied to every byte.
    function automatic logic [127:0] aff_lin_all(input logic [127:0] s);
        logic [127:0] o;
        logic [7:0] x;
        for (int i = 0; i < 16; i++) begin
            x = s[127-8*i -: 8];
            o[127-8*i -: 8] = x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]}
                                ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]};
        end
        return o;
    endfunction

    // Linear part of the inverse affine map, applied to every byte.
    function automatic logic [127:0] inv_aff_lin_all(input logic [127:0] s);
        logic [127:0] o;
        logic [7:0] x;
        for (int i = 0; i < 16; i++) begin
            x = s[127-8*i -: 8];
            o[127-8*i -: 8] = {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]};
        end
        return o;
    endfunction

endpackage

// File: rtl/aesrd_gf_inv.sv
// Multiplicative inverse in GF(2^8) (AES polynomial) as a^254; maps 0 to 0.
// Purely combinational; assumes nothing about its input.
module aesrd_gf_inv
    import aesrd_pkg::*;
(
    input  logic [7:0] a,
    output logic [7:0] y
);
    logic [7:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127;

    // Addition chain for the exponent 254.
    always_comb begin
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, a);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, a);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, a);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, a);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, a);
        y    = gf_mul(p127, p127);
    end
endmodule

// File: rtl/aesrd_enc_lin.sv
// Encryption linear stage after the shared inversion: ShiftRows, then the
// merged affine+MixColumns layer (affine only in the last round), then key.
// Assumes the input is already the byte-wise inverse of the state.
module aesrd_enc_lin
    import aesrd_pkg::*;
(
    input  logic [BLK_W-1:0] inv_v,
    input  logic [BLK_W-1:0] rk,
    input  logic             last,
    output logic [BLK_W-1:0] nxt
);
    logic [BLK_W-1:0] rot;
    logic [BLK_W-1:0] lin;

    // Row rotation, merged linear layer, constant and key addition.
    always_comb begin
        rot = shift_rows(inv_v);
        lin = last ? aff_lin_all(rot) : mix_all(aff_lin_all(rot));
        nxt = lin ^ AFF_K ^ rk;
    end
endmodule

// File: rtl/aesrd_dec_lin.sv
// Decryption linear stage after the shared inversion: InvShiftRows and key
// addition, then the merged InvMixColumns+inverse-affine layer that prepares
// the next round's inversion input (skipped in the last round).
// Assumes the register holds the inverse-affine image of the state.
module aesrd_dec_lin
    import aesrd_pkg::*;
(
    input  logic [BLK_W-1:0] inv_v,
    input  logic [BLK_W-1:0] rk,
    input  logic             last,
    output logic [BLK_W-1:0] nxt
);
    logic [BLK_W-1:0] keyed;

    // Key added before InvMixColumns so the round key is used as supplied.
    always_comb begin
        keyed = inv_shift_rows(inv_v) ^ rk;
        nxt   = last ? keyed : (inv_aff_lin_all(inv_mix_all(keyed)) ^ IAFF_K);
    end
endmodule

// File: rtl/aesrd_core.sv
// Round-per-cycle AES-128 datapath shared by encryption and decryption.
// One state register feeds sixteen inverters; the unused direction's linear
// path is held at zero; a single 4:1 selector picks the next state.
// Assumes an external scheduler drives rkey per edge as stated in R3.
module aesrd_core
    import aesrd_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [BLK_W-1:0] text,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] result,
    output logic             done
);
    localparam int RW = $clog2(NR + 1);
    localparam int NB = BLK_W / 8;

    logic [BLK_W-1:0] state_q;
    logic [BLK_W-1:0] inv_v;
    logic [BLK_W-1:0] enc_in, dec_in, enc_nxt, dec_nxt;
    logic [BLK_W-1:0] load_v, nxt;
    logic [RW-1:0]    rnd;
    logic             busy, mode_q, last, accept, eff_mode;

    assign last     = (rnd == RW'(NR));
    assign accept   = start && !busy;
    assign eff_mode = busy ? mode_q : mode;

    // Sixteen inverters on the register output, shared by both directions.
    for (genvar g = 0; g < NB; g++) begin : g_inv
        aesrd_gf_inv u_inv (
            .a (state_q[BLK_W-1-8*g -: 8]),
            .y (inv_v[BLK_W-1-8*g -: 8])
        );
    end

    // Operand isolation: the inactive direction sees an all-zero input.
    assign enc_in = inv_v & {BLK_W{~mode_q}};
    assign dec_in = inv_v & {BLK_W{mode_q}};

    aesrd_enc_lin u_enc (.inv_v(enc_in), .rk(rkey), .last(last), .nxt(enc_nxt));
    aesrd_dec_lin u_dec (.inv_v(dec_in), .rk(rkey), .last(last), .nxt(dec_nxt));

    // Initial key addition; decryption also pre-applies the inverse affine map.
    assign load_v = text ^ rkey;

    // The single 4:1 next-state selector.
    always_comb begin
        unique case ({busy, eff_mode})
            2'b00:   nxt = load_v;
            2'b01:   nxt = inv_aff_lin_all(load_v) ^ IAFF_K;
            2'b10:   nxt = enc_nxt;
            default: nxt = dec_nxt;
        endcase
    end

    // State register: loads on accepted start, advances every busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               state_q <= '0;
        else if (accept || busy)  state_q <= nxt;
    end

    // Round sequencing, mode latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            rnd    <= '0;
            mode_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                rnd    <= RW'(1);
                mode_q <= mode;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rnd <= rnd + RW'(1);
                end
            end
        end
    end

    assign result = state_q;
endmodule

// File: rtl/aesrd_chk.sv
// Property checker for aesrd_core, bound into every instance.
module aesrd_chk #(
    parameter int NR = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [127:0] result,
    input logic         busy,
    input logic [$clog2(NR+1)-1:0] rnd,
    input logic         mode_q
);
    localparam int RW = $clog2(NR + 1);
    localparam int CW = $clog2(NR + 2);

    logic [CW-1:0] cnt;
    logic          trk;

    // Cycles elapsed since the most recent accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            trk <= 1'b0;
        end else if (start && !busy) begin
            cnt <= '0;
            trk <= 1'b1;
        end else if (trk && cnt != CW'(NR)) begin
            cnt <= cnt + CW'(1);
        end else begin
            trk <= 1'b0;
        end
    end

    assert_done_on_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && cnt == CW'(NR)) |-> done);
    assert_done_only_on_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trk && cnt == CW'(NR)));
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd != RW'(NR)) |=> (busy && rnd == $past(rnd) + RW'(1)));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!done && result == '0));
    assert_mode_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd != RW'(NR)) |=> $stable(mode_q));
endmodule

bind aesrd_core aesrd_chk #(.NR(NR)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
    .busy(busy), .rnd(rnd), .mode_q(mode_q)
);

// File: tb/aesrd_core_bench.sv
module aesrd_core_bench;
    localparam int NR = 10;

    logic         clk = 1'b0;
    logic         rst_n, start, mode, done;
    logic [127:0] text, rkey, result;

    int total = 0;
    int bad   = 0;

    logic [7:0]   sb [256];
    logic [127:0] rks [NR+1];

    aesrd_core #(.NR(NR)) u_aesrd_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .text(text), .rkey(rkey), .result(result), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] baff(input logic [7:0] x);
        logic [7:0] o;
        for (int i = 0; i < 8; i++)
            o[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [4*(NR+1)];
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 4*(NR+1); i++) begin
            if (i % 4 == 0) begin
                w[i] = w[i-4] ^ subw({w[i-1][23:0], w[i-1][31:24]}) ^ {rc, 24'h0};
                rc   = bmul(rc, 8'h02);
            end else begin
                w[i] = w[i-4] ^ w[i-1];
            end
        end
        for (int k = 0; k <= NR; k++) rks[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one block; caller is at a negedge. Returns at the done cycle.
    task automatic run_op(input logic md, input logic [127:0] txt, input logic [127:0] key,
                          input bit noise, output logic [127:0] res, output bit tim_ok);
        expand(key);
        tim_ok = 1'b1;
        mode = md; text = txt; start = 1'b1;
        rkey = md ? rks[NR] : rks[0];
        for (int k = 1; k <= NR; k++) begin
            @(negedge clk);
            if (done) tim_ok = 1'b0;
            if (noise) begin start = 1'b1; text = ~txt; mode = ~md; end
            else start = 1'b0;
            rkey = md ? rks[NR-k] : rks[k];
        end
        @(negedge clk);
        start = 1'b0; mode = md;
        if (!done) tim_ok = 1'b0;
        res = result;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] r, r2, ct;
        bit t1, t2;
        bit tim_all;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 8'h00;
            for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            sb[x] = baff(iv);
        end

        rst_n = 1'b0; start = 1'b0; mode = 1'b0; text = '1; rkey = '1;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R7 done at reset", 128'(done), 128'h0);
        chk(result == '0, "R7 result at reset", result, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3 known answers, encryption.
        run_op(1'b0, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0, r, t1);
        chk(r == 128'h3925841d02dc09fbdc118597196a0b32, "R1 R3 known answer A enc", r, 128'h3925841d02dc09fbdc118597196a0b32);
        chk(t1, "R4 done timing A", 128'(t1), 128'h1);
        @(negedge clk);
        chk(done == 1'b0, "R4 done one cycle", 128'(done), 128'h0);

        run_op(1'b0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 1'b0, r, t1);
        chk(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 R3 known answer B enc", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R9 back-to-back start on the done cycle, decrypting.
        run_op(1'b1, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f, 1'b0, r, t1);
        chk(r == 128'h00112233445566778899aabbccddeeff, "R2 R9 known answer B dec back-to-back", r, 128'h00112233445566778899aabbccddeeff);
        chk(t1, "R9 done timing back-to-back", 128'(t1), 128'h1);

        // R6 idle hold with moving inputs.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            text = {4{$urandom}}; rkey = {4{$urandom}}; mode = ~mode;
        end
        chk(result == r, "R6 idle hold", result, r);
        @(negedge clk);

        // R5/R8 start and mode toggled throughout processing.
        run_op(1'b1, 128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1, r, t1);
        chk(r == 128'h3243f6a8885a308d313198a2e0370734, "R2 R5 R8 known answer A dec with noise", r, 128'h3243f6a8885a308d313198a2e0370734);
        chk(t1, "R5 timing under start noise", 128'(t1), 128'h1);
        @(negedge clk);
        run_op(1'b0, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1, r, t1);
        chk(r == 128'h3925841d02dc09fbdc118597196a0b32, "R5 R8 known answer A enc with noise", r, 128'h3925841d02dc09fbdc118597196a0b32);

        // R1/R2 sweep: walking byte value, rotating position, varying key.
        tim_all = 1'b1;
        for (int v = 0; v < 256; v++) begin
            logic [127:0] pt = '0;
            logic [127:0] ky = {16{8'(v)}} ^ 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
            pt[127-8*(v%16) -: 8] = 8'(v);
            run_op(1'b0, pt, ky, 1'b0, ct, t1);
            run_op(1'b1, ct, ky, 1'b0, r2, t2);
            chk(r2 == pt, "R1 R2 sweep round trip", r2, pt);
            tim_all = tim_all & t1 & t2;
        end
        chk(tim_all, "R4 sweep timing", 128'(tim_all), 128'h1);

        // Random round trips.
        for (int n = 0; n < 16; n++) begin
            logic [127:0] pt = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] ky = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            run_op(1'b0, pt, ky, 1'b0, ct, t1);
            @(negedge clk);
            run_op(1'b1, ct, ky, 1'b0, r2, t2);
            chk(r2 == pt, "R2 random round trip", r2, pt);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule